// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block services a translation lookaside buffer miss. It takes the missed virtual address and the translation table base, reads a first-level descriptor from memory over a single-word read port with a request/acknowledge handshake and, if that descriptor points to a second-level table, reads a second-level descriptor as well. It ends each walk with exactly one outcome: a fill record for the TLB and the permission checker, or a translation fault that names its level and the domain.

A fill record holds the physical address of the missed access, a mapping kind (section, large page or small page), four 2-bit access-permission fields, the domain number and the cacheable and bufferable bits. Sections replicate their single permission field into all four slots, so the consumer sees one record format. The walker accepts one miss at a time and drops miss requests that arrive while a walk is in progress.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `mem_req`, `fill_valid` and `fault_valid` are all 0.
- R2: One cycle after a miss is accepted, `mem_req` is 1 with `mem_addr` = {ttb[31:14], va[31:20], 2'b00}; the request and its address stay unchanged until the cycle in which `mem_ack` is seen.
- R3: A first-level descriptor whose bits [1:0] are 00 or 11 ends the walk with `fault_valid`=1, `fault_page`=0, `fault_domain` = descriptor[8:5] and `fault_va` = the missed address, and no second read is made.
- R4: A first-level descriptor with bits [1:0] = 10 is a section: `fill_kind`=2'b00, `fill_pa` = {desc[31:20], va[19:0]}, every 2-bit field of `fill_ap` = desc[11:10], `fill_domain` = desc[8:5], `fill_c` = desc[3], `fill_b` = desc[2].
- R5: A first-level descriptor with bits [1:0] = 01 causes a second read at `mem_addr` = {desc[31:10], va[19:12], 2'b00}, issued in the cycle after the first acknowledge.
- R6: A second-level descriptor whose bits [1:0] are 00 or 11 ends the walk with `fault_valid`=1, `fault_page`=1, `fault_domain` = first-level descriptor[8:5] and `fault_va` = the missed address.
- R7: A second-level descriptor with bits [1:0] = 10 is a 4 kB page: `fill_kind`=2'b10, `fill_pa` = {entry[31:12], va[11:0]}, `fill_ap` = entry[11:4], `fill_c` = entry[3], `fill_b` = entry[2], `fill_domain` = first-level descriptor[8:5].
- R8: A second-level descriptor with bits [1:0] = 01 is a 64 kB page: `fill_kind`=2'b01, `fill_pa` = {entry[31:16], va[15:0]}, with permission, cache, buffer and domain fields as in R7.
- R9: The outcome is presented in the cycle after the last acknowledge, for one cycle only, with exactly one of `fill_valid` and `fault_valid` set and no memory request; in the next cycle `busy` is 0.
- R10: Miss requests raised while `busy` is 1 are ignored: the walk in progress keeps its addresses and outcome, and no new walk starts when it ends.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | A TLB miss is pending |
| miss_va | input | 32 | Virtual address that missed |
| ttb | input | 32 | Translation table base; bits [13:0] unused |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 32 | Word read address |
| mem_ack | input | 1 | Read data valid, request complete |
| mem_rdata | input | 32 | Read data |
| fill_valid | output | 1 | Fill record valid (one cycle) |
| fill_kind | output | 2 | 00 section, 01 large page, 10 small page |
| fill_pa | output | 32 | Physical address of the missed access |
| fill_ap | output | 8 | Four access-permission fields |
| fill_domain | output | 4 | Domain number |
| fill_c | output | 1 | Cacheable |
| fill_b | output | 1 | Bufferable |
| fault_valid | output | 1 | Translation fault (one cycle) |
| fault_page | output | 1 | 0 first-level fault, 1 second-level fault |
| fault_domain | output | 4 | Domain bits from the first-level descriptor |
| fault_va | output | 32 | Virtual address that faulted |

## Verification
The first read request is due one cycle after the edge that accepts a miss, the second-level request one cycle after the first acknowledge edge, and the outcome one cycle after the final acknowledge edge, lasting exactly one cycle before the walker is idle again. The bench drives every input on the falling edge and samples on the next falling edge after each rising edge that should change the outputs, so each check lands in the single cycle where the result is due. All four first-level type codes are swept against all four second-level type codes, with several addresses and acknowledge delays, and miss requests are injected during some walks.

// File: rtl/ptw_pkg.sv
// Shared constants and types for the table walker.
// Assumes 32-bit virtual and physical addresses and word-sized descriptors.
package ptw_pkg;
    localparam int AW         = 32;  // address and descriptor width
    localparam int TBL_LSB    = 14;  // table base alignment
    localparam int SEC_LSB    = 20;  // section offset width
    localparam int L2BASE_LSB = 10;  // second-level table alignment
    localparam int SMALL_LSB  = 12;  // small page offset width
    localparam int LARGE_LSB  = 16;  // large page offset width
    localparam int APW        = 8;   // four 2-bit permission fields
    localparam int DOMW       = 4;   // domain number width

    typedef enum logic [1:0] {
        KIND_SECTION = 2'b00,
        KIND_LARGE   = 2'b01,
        KIND_SMALL   = 2'b10
    } map_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_L1   = 2'b01,
        ST_L2   = 2'b10,
        ST_RESP = 2'b11
    } walk_st_e;

    typedef struct packed {
        logic [AW-1:0]   pa;
        logic [APW-1:0]  ap;
        logic [DOMW-1:0] dom;
        logic            c;
        logic            b;
        map_kind_e       kind;
    } fill_t;
endpackage

// File: rtl/pt_fetch_addr.sv
// Forms the descriptor read address for either walk level.
// Assumes ttb_hi already holds only the aligned base bits.
module pt_fetch_addr
    import ptw_pkg::*;
(
    input  logic [AW-1:TBL_LSB] ttb_hi,
    input  logic [AW-1:0]       va,
    input  logic [AW-1:0]       l1_desc,
    input  logic                sel_l2,
    output logic [AW-1:0]       addr
);
    localparam int IDX1_W = AW - SEC_LSB;
    localparam int IDX2_W = SEC_LSB - SMALL_LSB;

    logic [AW-1:0] l1_addr;
    logic [AW-1:0] l2_addr;

    // Concatenate base and virtual index slices for each level.
    always_comb begin
        l1_addr = {ttb_hi, va[AW-1 -: IDX1_W], 2'b00};
        l2_addr = {l1_desc[AW-1:L2BASE_LSB], va[SEC_LSB-1 -: IDX2_W], 2'b00};
        addr    = sel_l2 ? l2_addr : l1_addr;
    end
endmodule

// File: rtl/pt_l1_decode.sv
// Decodes a first-level descriptor: fault, table pointer or section.
// Assumes the descriptor is a raw word straight from memory.
module pt_l1_decode
    import ptw_pkg::*;
(
    input  logic [AW-1:0]   desc,
    input  logic [AW-1:0]   va,
    output logic            is_fault,
    output logic            is_table,
    output logic [DOMW-1:0] dom,
    output fill_t           sec_fill
);
    // Classify type code and build the section record.
    always_comb begin
        is_fault      = (desc[1:0] == 2'b00) || (desc[1:0] == 2'b11);
        is_table      = (desc[1:0] == 2'b01);
        dom           = desc[8:5];
        sec_fill.pa   = {desc[AW-1:SEC_LSB], va[SEC_LSB-1:0]};
        sec_fill.ap   = {4{desc[11:10]}};
        sec_fill.dom  = desc[8:5];
        sec_fill.c    = desc[3];
        sec_fill.b    = desc[2];
        sec_fill.kind = KIND_SECTION;
    end
endmodule

// File: rtl/pt_l2_decode.sv
// Decodes a second-level descriptor into a large or small page record.
// Assumes the domain comes from the first-level descriptor.
module pt_l2_decode
    import ptw_pkg::*;
(
    input  logic [AW-1:0]   desc,
    input  logic [AW-1:0]   va,
    input  logic [DOMW-1:0] dom,
    output logic            is_fault,
    output fill_t           pg_fill
);
    logic is_large;

    // Classify type code and build the page record.
    always_comb begin
        is_fault     = (desc[1:0] == 2'b00) || (desc[1:0] == 2'b11);
        is_large     = (desc[1:0] == 2'b01);
        pg_fill.ap   = desc[11:4];
        pg_fill.dom  = dom;
        pg_fill.c    = desc[3];
        pg_fill.b    = desc[2];
        if (is_large) begin
            pg_fill.pa   = {desc[AW-1:LARGE_LSB], va[LARGE_LSB-1:0]};
            pg_fill.kind = KIND_LARGE;
        end else begin
            pg_fill.pa   = {desc[AW-1:SMALL_LSB], va[SMALL_LSB-1:0]};
            pg_fill.kind = KIND_SMALL;
        end
    end
endmodule

// File: rtl/pt_walker.sv
// Two-level translation table walker. Runs one walk per accepted miss,
// issues up to two word reads and returns one fill or one fault for a
// single cycle. Assumes the memory side keeps mem_rdata valid with mem_ack.
module pt_walker
    import ptw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            miss_valid,
    input  logic [31:0]     miss_va,
    input  logic [31:0]     ttb,
    output logic            busy,
    output logic            mem_req,
    output logic [31:0]     mem_addr,
    input  logic            mem_ack,
    input  logic [31:0]     mem_rdata,
    output logic            fill_valid,
    output logic [1:0]      fill_kind,
    output logic [31:0]     fill_pa,
    output logic [7:0]      fill_ap,
    output logic [3:0]      fill_domain,
    output logic            fill_c,
    output logic            fill_b,
    output logic            fault_valid,
    output logic            fault_page,
    output logic [3:0]      fault_domain,
    output logic [31:0]     fault_va
);
    walk_st_e            st_q;
    logic [AW-1:0]       va_q;
    logic [AW-1:TBL_LSB] ttb_q;
    logic [AW-1:0]       l1_q;
    fill_t               fill_q;
    logic                fill_v_q;
    logic                fault_v_q;
    logic                fault_pg_q;
    logic [DOMW-1:0]     fault_dom_q;

    logic                l1_fault, l1_table, l2_fault;
    logic [DOMW-1:0]     l1_dom;
    fill_t               sec_fill, pg_fill;

    pt_fetch_addr u_addr (
        .ttb_hi  (ttb_q),
        .va      (va_q),
        .l1_desc (l1_q),
        .sel_l2  (st_q == ST_L2),
        .addr    (mem_addr)
    );

    pt_l1_decode u_l1 (
        .desc     (mem_rdata),
        .va       (va_q),
        .is_fault (l1_fault),
        .is_table (l1_table),
        .dom      (l1_dom),
        .sec_fill (sec_fill)
    );

    pt_l2_decode u_l2 (
        .desc     (mem_rdata),
        .va       (va_q),
        .dom      (l1_q[8:5]),
        .is_fault (l2_fault),
        .pg_fill  (pg_fill)
    );

    // Walk sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            va_q        <= '0;
            ttb_q       <= '0;
            l1_q        <= '0;
            fill_q      <= '0;
            fill_v_q    <= 1'b0;
            fault_v_q   <= 1'b0;
            fault_pg_q  <= 1'b0;
            fault_dom_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (miss_valid) begin
                        va_q  <= miss_va;
                        ttb_q <= ttb[AW-1:TBL_LSB];
                        st_q  <= ST_L1;
                    end
                end
                ST_L1: begin
                    if (mem_ack) begin
                        l1_q <= mem_rdata;
                        if (l1_fault) begin
                            fault_v_q   <= 1'b1;
                            fault_pg_q  <= 1'b0;
                            fault_dom_q <= l1_dom;
                            st_q        <= ST_RESP;
                        end else if (l1_table) begin
                            st_q <= ST_L2;
                        end else begin
                            fill_v_q <= 1'b1;
                            fill_q   <= sec_fill;
                            st_q     <= ST_RESP;
                        end
                    end
                end
                ST_L2: begin
                    if (mem_ack) begin
                        if (l2_fault) begin
                            fault_v_q   <= 1'b1;
                            fault_pg_q  <= 1'b1;
                            fault_dom_q <= l1_q[8:5];
                        end else begin
                            fill_v_q <= 1'b1;
                            fill_q   <= pg_fill;
                        end
                        st_q <= ST_RESP;
                    end
                end
                default: begin
                    fill_v_q  <= 1'b0;
                    fault_v_q <= 1'b0;
                    st_q      <= ST_IDLE;
                end
            endcase
        end
    end

    // Drive port view of state and result.
    always_comb begin
        busy         = (st_q != ST_IDLE);
        mem_req      = (st_q == ST_L1) || (st_q == ST_L2);
        fill_valid   = fill_v_q;
        fill_kind    = fill_q.kind;
        fill_pa      = fill_q.pa;
        fill_ap      = fill_q.ap;
        fill_domain  = fill_q.dom;
        fill_c       = fill_q.c;
        fill_b       = fill_q.b;
        fault_valid  = fault_v_q;
        fault_page   = fault_pg_q;
        fault_domain = fault_dom_q;
        fault_va     = va_q;
    end
endmodule

// File: rtl/pt_walker_chk.sv
// Protocol and result checks for pt_walker, attached by bind.
module pt_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        miss_valid,
    input logic [31:0] miss_va,
    input logic        busy,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_ack,
    input logic        fill_valid,
    input logic [1:0]  fill_kind,
    input logic [31:0] fill_pa,
    input logic        fault_valid,
    input logic [31:0] fault_va
);
    logic [31:0] va_seen;

    // Record the address of each accepted miss.
    always_ff @(posedge clk) begin
        if (!rst_n)                  va_seen <= '0;
        else if (miss_valid && !busy) va_seen <= miss_va;
    end

    p_req_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    p_addr_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_valid && fault_valid));

    p_result_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid || fault_valid) |=> (!fill_valid && !fault_valid && !busy));

    p_no_req_at_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid || fault_valid) |-> !mem_req);

    p_section_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_kind == 2'b00) |-> (fill_pa[19:0] == va_seen[19:0]));

    p_small_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_kind == 2'b10) |-> (fill_pa[11:0] == va_seen[11:0]));

    p_fault_va_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (fault_va == va_seen));
endmodule

bind pt_walker pt_walker_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .miss_valid  (miss_valid),
    .miss_va     (miss_va),
    .busy        (busy),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack),
    .fill_valid  (fill_valid),
    .fill_kind   (fill_kind),
    .fill_pa     (fill_pa),
    .fault_valid (fault_valid),
    .fault_va    (fault_va)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic [31:0] miss_va = '0;
    logic [31:0] ttb = '0;
    logic        busy, mem_req, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_rdata = '0;
    logic        fill_valid, fill_c, fill_b, fault_valid, fault_page;
    logic [1:0]  fill_kind;
    logic [31:0] fill_pa, fault_va;
    logic [7:0]  fill_ap;
    logic [3:0]  fill_domain, fault_domain;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pt_walker u_dut (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_va(miss_va),
        .ttb(ttb), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .fill_valid(fill_valid),
        .fill_kind(fill_kind), .fill_pa(fill_pa), .fill_ap(fill_ap),
        .fill_domain(fill_domain), .fill_c(fill_c), .fill_b(fill_b),
        .fault_valid(fault_valid), .fault_page(fault_page),
        .fault_domain(fault_domain), .fault_va(fault_va)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        summary();
    end

    task automatic run_walk(input logic [31:0] va, input logic [31:0] tb,
                            input logic [31:0] d1, input logic [31:0] d2,
                            input int dly1, input int dly2, input bit junk);
        logic [31:0] a1, a2, exp_pa;
        logic [7:0]  exp_ap;
        logic [1:0]  exp_kind;
        bit          is_fault, is_page_fault, is_page;
        a1 = {tb[31:14], va[31:20], 2'b00};
        a2 = {d1[31:10], va[19:12], 2'b00};
        is_page = (d1[1:0] == 2'b01);
        is_fault = (d1[1:0] == 2'b00) || (d1[1:0] == 2'b11) ||
                   (is_page && (d2[1:0] == 2'b00 || d2[1:0] == 2'b11));
        is_page_fault = is_page && is_fault;
        if (!is_page) begin
            exp_pa = {d1[31:20], va[19:0]};
            exp_ap = {4{d1[11:10]}};
            exp_kind = 2'b00;
        end else if (d2[1:0] == 2'b01) begin
            exp_pa = {d2[31:16], va[15:0]};
            exp_ap = d2[11:4];
            exp_kind = 2'b01;
        end else begin
            exp_pa = {d2[31:12], va[11:0]};
            exp_ap = d2[11:4];
            exp_kind = 2'b10;
        end

        @(negedge clk);
        miss_valid = 1'b1; miss_va = va; ttb = tb;
        @(negedge clk);
        miss_valid = junk; miss_va = ~va; ttb = ~tb;
        chk(mem_req == 1'b1 && busy == 1'b1, "R2 request raised", {31'd0, mem_req}, 32'd1);
        chk(mem_addr == a1, "R2 first-level address", mem_addr, a1);
        for (int i = 0; i < dly1; i++) begin
            @(negedge clk);
            chk(mem_req == 1'b1 && mem_addr == a1, "R2 request held", mem_addr, a1);
        end
        mem_ack = 1'b1; mem_rdata = d1; miss_valid = 1'b0;
        @(negedge clk);
        mem_ack = 1'b0; mem_rdata = 32'hDEAD_BEEF;
        if (is_page) begin
            chk(mem_req == 1'b1 && !fill_valid && !fault_valid, "R5 second request", {31'd0, mem_req}, 32'd1);
            chk(mem_addr == a2, "R5 second-level address", mem_addr, a2);
            for (int i = 0; i < dly2; i++) begin
                @(negedge clk);
                chk(mem_req == 1'b1 && mem_addr == a2, "R5 request held", mem_addr, a2);
            end
            mem_ack = 1'b1; mem_rdata = d2;
            @(negedge clk);
            mem_ack = 1'b0; mem_rdata = 32'hDEAD_BEEF;
        end
        // Outcome cycle.
        chk(mem_req == 1'b0, "R9 no request with result", {31'd0, mem_req}, 32'd0);
        if (is_fault) begin
            chk(fault_valid && !fill_valid, is_page_fault ? "R6 fault flag" : "R3 fault flag",
                {30'd0, fault_valid, fill_valid}, 32'd2);
            chk(fault_page == is_page_fault, is_page_fault ? "R6 fault level" : "R3 fault level",
                {31'd0, fault_page}, {31'd0, is_page_fault});
            chk(fault_domain == d1[8:5], is_page_fault ? "R6 fault domain" : "R3 fault domain",
                {28'd0, fault_domain}, {28'd0, d1[8:5]});
            chk(fault_va == va, junk ? "R10 fault address" : "R3 fault address", fault_va, va);
        end else begin
            chk(fill_valid && !fault_valid, "R9 fill flag", {30'd0, fill_valid, fault_valid}, 32'd2);
            chk(fill_kind == exp_kind, exp_kind == 2'b00 ? "R4 kind" : (exp_kind == 2'b01 ? "R8 kind" : "R7 kind"),
                {30'd0, fill_kind}, {30'd0, exp_kind});
            chk(fill_pa == exp_pa, exp_kind == 2'b00 ? "R4 pa" : (exp_kind == 2'b01 ? "R8 pa" : "R7 pa"),
                fill_pa, exp_pa);
            chk(fill_ap == exp_ap, exp_kind == 2'b00 ? "R4 ap" : "R7 ap", {24'd0, fill_ap}, {24'd0, exp_ap});
            chk(fill_domain == d1[8:5], exp_kind == 2'b00 ? "R4 domain" : "R7 domain",
                {28'd0, fill_domain}, {28'd0, d1[8:5]});
            if (!is_page)
                chk({fill_c, fill_b} == d1[3:2], "R4 c/b", {30'd0, fill_c, fill_b}, {30'd0, d1[3:2]});
            else
                chk({fill_c, fill_b} == d2[3:2], "R7 c/b", {30'd0, fill_c, fill_b}, {30'd0, d2[3:2]});
        end
        @(negedge clk);
        chk(!fill_valid && !fault_valid && !busy, "R9 single-cycle result",
            {29'd0, fill_valid, fault_valid, busy}, 32'd0);
        chk(!mem_req, junk ? "R10 no walk after ignored miss" : "R9 idle", {31'd0, mem_req}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && !fill_valid && !fault_valid, "R1 reset state",
            {28'd0, busy, mem_req, fill_valid, fault_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req, "R1 idle after reset", {30'd0, busy, mem_req}, 32'd0);
        for (int t1 = 0; t1 < 4; t1++) begin
            for (int t2 = 0; t2 < 4; t2++) begin
                for (int v = 0; v < 3; v++) begin
                    logic [31:0] va, tb, d1, d2;
                    va = 32'h1234_5678 ^ (32'h9E37_79B9 * (t1 * 16 + t2 * 4 + v + 1));
                    tb = 32'hA5A5_3FFF ^ (32'h0001_C000 * (v + t2));
                    d1 = ((32'h6B8B_4567 * (t1 * 7 + t2 * 3 + v + 1)) & ~32'h3) | t1[1:0];
                    d2 = ((32'h327B_23C6 * (t2 * 5 + v + t1 + 2)) & ~32'h3) | t2[1:0];
                    run_walk(va, tb, d1, d2, v, (v + 1) % 3, v == 1);
                end
            end
        end
        summary();
    end
endmodule